// File: doc/BRIEF.md
# APB Completer with Phase Tracking from PSEL

This block is the slave end of an APB3/APB4 link. It sits in front of a small bank of 32-bit registers. It never looks at PENABLE. It works out which phase a transfer is in from two things: the history of PSEL and its own completion handshake. The first cycle in which PSEL is seen high, either from rest or right after a completed transfer, is taken as the setup cycle. The cycle after it is always taken as the access cycle. The access phase then lasts until the block raises PREADY.

Address and direction are latched in the setup cycle. A registered one-cycle request strobe then starts the register backend in the first access cycle. The backend acknowledges either at once or after a fixed number of wait states, depending on a per-register parameter mask. Each acknowledge produces PREADY, with read data or an error flag valid in that same cycle. Write data and byte strobes are taken in the completing cycle.

The PENABLE pin stays on the port list so that standard masters can connect to it. It has no effect on decoding or timing.

Top module: `apb_phase_slave`

## Requirements
- R1: The first cycle with PSEL high, from rest or right after a completion, is the setup cycle. PADDR and PWRITE are latched in it, and PREADY is low during it.
- R2: The cycle after setup is an access cycle whatever PENABLE does. PENABLE held low, driven per protocol, or toggled at random gives identical PREADY timing, PRDATA, PSLVERR and register contents.
- R3: The backend request is a registered one-cycle strobe in the first access cycle. The word index is PADDR[ADDR_W-1:2]. A register whose bit in SLOW_MASK is 0 completes in the first access cycle (no wait state). A register whose bit is 1 completes after WAIT_CYC wait states.
- R4: If PSEL stays high after a completion, the next cycle is a new setup cycle. Two back-to-back fast transfers therefore take exactly four clock cycles.
- R5: On a read completion, PRDATA equals the addressed register. In every other cycle PRDATA is zero.
- R6: A write takes effect at the end of its PREADY cycle. Byte b of the register is replaced by PWDATA[8b+7:8b] only where PSTRB[b] is 1, and the other bytes keep their value. Registers never change outside a write completion.
- R7: A word index of NREGS or more is unmapped. Such an access completes without a wait state, with PSLVERR high only in the PREADY cycle. A read of it returns zero, and a write to it changes no register.
- R8: While PRESETn is low, the block returns to rest, drops any pending request and sets register i to RST_BASE ^ (i * 32'h01010101). After an abandoned transfer, a new transfer starts with a fresh setup cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Enable from master, present for compatibility, ignored |
| paddr | input | ADDR_W | Byte address, word index in bits ADDR_W-1:2 |
| pwrite | input | 1 | 1 for write, 0 for read |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte write enables |
| prdata | output | 32 | Read data, valid with PREADY |
| pready | output | 1 | Transfer completion |
| pslverr | output | 1 | Error on unmapped address, only with PREADY |

## Verification
Transfers are driven under three PENABLE behaviours: tied low, driven per protocol, and random on every cycle. The same model expectations must hold under all three, which shows that phase decoding ignores that pin. The mix covers isolated transfers, back-to-back transfers with PSEL held high, fast and wait-stated registers, and unmapped addresses. These separate the setup-to-access step, the PSEL-only re-entry into setup, latency selection and error completion. Partial byte strobes and a reset that lands in the middle of a transfer check write merging and the return to reset values.

// File: rtl/apb_phase_slave.sv
module apb_phase_slave #(
  parameter int ADDR_W   = 8,
  parameter int NREGS    = 6,
  parameter int WAIT_CYC = 2,
  parameter logic [NREGS-1:0] SLOW_MASK = 6'b100100,
  parameter logic [31:0] RST_BASE = 32'hC0DE_0000
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrite,
  input  logic [31:0]       pwdata,
  input  logic [3:0]        pstrb,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr
);
  localparam int IW    = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam int NSLOT = 2 ** IW;
  localparam int WW    = ADDR_W - 2;
  localparam int CW    = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;
  localparam logic [NSLOT-1:0] SLOW_PAD = NSLOT'(SLOW_MASK);

  typedef enum logic {ST_IDLE, ST_ACC} st_t;

  st_t               st;
  logic              req_q, w_q, bk_busy;
  logic [ADDR_W-1:0] a_q;
  logic [CW-1:0]     bk_cnt;
  logic [31:0]       regs [NSLOT];
  logic [NSLOT*32-1:0] regs_flat;

  wire          setup = (st == ST_IDLE) && psel;
  wire [WW-1:0] widx  = a_q[ADDR_W-1:2];
  wire [IW-1:0] sel   = widx[IW-1:0];
  wire          hit   = widx < WW'(NREGS);
  wire          slow  = hit && SLOW_PAD[sel] && (WAIT_CYC > 0);
  wire          ack   = (req_q && !slow) || (bk_busy && bk_cnt == '0);

  assign pready  = (st == ST_ACC) && ack;
  assign pslverr = pready && !hit;
  assign prdata  = (pready && !w_q && hit) ? regs[sel] : '0;

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      st    <= ST_IDLE;
      req_q <= 1'b0;
      a_q   <= '0;
      w_q   <= 1'b0;
    end else begin
      req_q <= setup;
      if (setup) begin
        st  <= ST_ACC;
        a_q <= paddr;
        w_q <= pwrite;
      end else if (pready) begin
        st <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      bk_busy <= 1'b0;
      bk_cnt  <= '0;
    end else if (req_q && slow) begin
      bk_busy <= 1'b1;
      bk_cnt  <= CW'(WAIT_CYC - 1);
    end else if (bk_busy) begin
      if (bk_cnt == '0) bk_busy <= 1'b0;
      else              bk_cnt  <= bk_cnt - 1'b1;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_reg
    for (genvar b = 0; b < 4; b++) begin : g_byte
      always_ff @(posedge pclk) begin
        if (!presetn)
          regs[i][8*b +: 8] <= 8'(RST_BASE[8*b +: 8] ^ 8'(i));
        else if (pready && w_q && hit && sel == IW'(i) && pstrb[b])
          regs[i][8*b +: 8] <= pwdata[8*b +: 8];
      end
    end
    assign regs_flat[32*i +: 32] = regs[i];
  end

  wire unused_ok = &{1'b0, penable};
endmodule

module apb_phase_slave_chk #(
  parameter int FLAT_W = 256
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              pready,
  input logic              pslverr,
  input logic              req,
  input logic [FLAT_W-1:0] regs_flat
);
  a_r1_setup_not_ready: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(psel) |-> !pready);
  a_r3_ready_after_select: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> $past(psel));
  a_r3_strobe_single: assert property (@(posedge pclk) disable iff (!presetn)
    req |=> !req);
  a_r4_setup_between: assert property (@(posedge pclk) disable iff (!presetn)
    pready |=> !pready);
  a_r6_regs_hold: assert property (@(posedge pclk) disable iff (!presetn)
    !pready |=> $stable(regs_flat));
  a_r7_err_with_ready: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> pready);
endmodule

bind apb_phase_slave apb_phase_slave_chk #(.FLAT_W(NSLOT*32)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .pready(pready),
  .pslverr(pslverr), .req(req_q), .regs_flat(regs_flat)
);

// File: tb/apb_phase_slave_bench.sv
module apb_phase_slave_bench;
  localparam int PERIOD = 10;
  localparam int NREGS = 6;
  localparam int WAITC = 2;
  localparam logic [NREGS-1:0] SMASK = 6'b100100;
  localparam logic [31:0] RBASE = 32'hC0DE_0000;

  logic clk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic [3:0] pstrb = 0;
  logic pready, pslverr;
  int n_chk = 0, n_bad = 0, cyc = 0, last_waits = 0;
  logic [31:0] model [NREGS];

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  apb_phase_slave #(.ADDR_W(8), .NREGS(NREGS), .WAIT_CYC(WAITC),
    .SLOW_MASK(SMASK), .RST_BASE(RBASE)) u_apb_phase_slave (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .pstrb(pstrb),
    .prdata(prdata), .pready(pready), .pslverr(pslverr));

  function automatic logic [31:0] rst_val(int i);
    return RBASE ^ (i * 32'h0101_0101);
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    for (int b = 0; b < 4; b++) if (s[b]) o[8*b +: 8] = n[8*b +: 8];
    return o;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic reset_model();
    for (int i = 0; i < NREGS; i++) model[i] = rst_val(i);
  endtask

  function automatic logic rnd_bit();
    return 1'($urandom % 2);
  endfunction

  // pm: 0 PENABLE tied low, 1 per protocol, 2 random every cycle
  task automatic xfer(logic [7:0] a, bit wr, logic [31:0] d, logic [3:0] s, int pm);
    int idx = int'(a[7:2]);
    bit hit = idx < NREGS;
    bit slow = hit && SMASK[idx];
    int w = 0;
    logic [31:0] er;
    psel = 1; paddr = a; pwrite = wr; pwdata = d; pstrb = wr ? s : 4'h0;
    penable = (pm == 2) ? rnd_bit() : 1'b0;
    @(negedge clk);
    chk(!pready, "R1", "pready in setup", 32'(pready), 0);
    @(posedge clk); #1;
    penable = (pm == 1) ? 1'b1 : (pm == 2) ? rnd_bit() : 1'b0;
    forever begin
      @(negedge clk);
      if (pready) break;
      w++;
      if (w > 40) break;
      @(posedge clk); #1;
      if (pm == 2) penable = rnd_bit();
    end
    last_waits = w;
    chk(w == (slow ? WAITC : 0), "R3", "wait states", 32'(w), 32'(slow ? WAITC : 0));
    chk(pslverr == !hit, "R7", "pslverr", 32'(pslverr), 32'(!hit));
    er = (!wr && hit) ? model[idx] : 32'h0;
    chk(prdata == er, hit ? "R5" : "R7", "prdata", prdata, er);
    if (wr && hit) model[idx] = merge(model[idx], d, s);
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    psel = 0; penable = 0; pwrite = 0; pstrb = 0;
    repeat (n) begin @(posedge clk); #1; end
    chk(prdata == 0, "R5", "prdata idle", prdata, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    int t0;
    void'($urandom(32'h5EED));
    reset_model();
    repeat (3) @(posedge clk);
    #1;
    chk(!pready && !pslverr && prdata == 0, "R8", "outputs in reset", {pready, pslverr, prdata[29:0]}, 0);
    presetn = 1;
    idle(1);
    for (int i = 0; i < NREGS; i++) xfer(8'(4*i), 0, 0, 0, 1);
    idle(1);

    // R6 partial strobes then read back
    xfer(8'h04, 1, 32'h1122_3344, 4'b0101, 1);
    xfer(8'h04, 0, 0, 0, 0);
    chk(model[1] == merge(rst_val(1), 32'h1122_3344, 4'b0101), "R6", "merged bytes model",
        model[1], merge(rst_val(1), 32'h1122_3344, 4'b0101));
    idle(2);

    // R7 unmapped write leaves every register unchanged
    xfer(8'hFC, 1, 32'hDEAD_BEEF, 4'hF, 1);
    for (int i = 0; i < NREGS; i++) xfer(8'(4*i), 0, 0, 0, 2);
    idle(1);

    // R2 same slow read under each PENABLE behaviour
    for (int pm = 0; pm < 3; pm++) begin
      xfer(8'h08, 0, 0, 0, pm);
      chk(last_waits == WAITC, "R2", "waits with penable mode", 32'(last_waits), WAITC);
      idle(1);
    end

    // R4 two fast transfers back to back take four cycles
    t0 = cyc;
    xfer(8'h00, 1, 32'hA5A5_0001, 4'hF, 0);
    xfer(8'h00, 0, 0, 0, 0);
    chk(cyc - t0 == 4, "R4", "back-to-back cycles", 32'(cyc - t0), 4);
    idle(1);

    // R8 reset in the middle of a slow transfer
    psel = 1; paddr = 8'h14; pwrite = 1; pwdata = 32'h0; pstrb = 4'hF;
    @(posedge clk); #1;
    presetn = 0; penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0;
    @(negedge clk);
    chk(!pready, "R8", "pready during reset", 32'(pready), 0);
    @(posedge clk); #1;
    presetn = 1; reset_model();
    for (int i = 0; i < NREGS; i++) begin
      xfer(8'(4*i), 0, 0, 0, 1);
      chk(model[i] == rst_val(i), "R8", "reset value", model[i], rst_val(i));
    end
    idle(1);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(4 * ($urandom % NREGS));
      bit wr = rnd_bit();
      xfer(a, wr, $urandom, 4'($urandom), int'($urandom % 3));
      if ($urandom % 3 == 0) idle(int'($urandom % 3) + 1);
    end
    idle(2);
    finish_run();
  end
endmodule